// File: doc/BRIEF.md
# Flash Query and Identifier Read Responder

This block forms the read word that a parallel flash bank returns while it sits in query mode or in identifier mode. The bank is made of several identical devices placed side by side on the data bus. Each device may run at a width below its largest supported width. The block takes the byte address of a read, the access width, a mode select and three width settings, all as base-2 logarithms of a byte count. From these it rescales the address to the index a single device would see. It then looks up a query-table byte or an identifier code, forms the one-device response and copies it into every device lane of the bank. A read wider than the bank is built from several bank-wide responses.

The width settings are captured into internal registers only in cycles without a request, so a setting that changes together with a request does not affect that read. Each request returns its word one clock later, with a one-cycle valid pulse. The word then holds until the next request.

Top module: `flash_query_resp`

## Requirements
- R1: While reset is asserted and right after it, `rvalid` is 0 and `rdata` is all zeros. The captured width settings reset to a single byte-wide device on a byte-wide bank.
- R2: A request in one cycle gives `rvalid` = 1 and the new `rdata` after the next rising edge. A cycle with no request gives `rvalid` = 0 after the next edge and leaves `rdata` unchanged.
- R3: For each bank-wide piece of the read, the lookup index is that piece's byte address shifted right by bank_lw + max_lw − dev_lw, using the captured settings.
- R4: In query mode an index of 82 or more returns a zero byte. Index 81 is the last table entry and holds the parameter `QTAB_LAST`.
- R5: The query table holds 0x51, 0x52, 0x59 ("QRY") at indices 0x10, 0x11, 0x12 and 0x01, 0x00 at 0x13, 0x14. All other entries below 81 are zero.
- R6: In query mode the table byte goes in byte 0 of each device lane, and the other bytes of a full-width device are zero. A device used in byte mode below its largest width repeats the byte and does not pad it.
- R7: The one-device response, `dev_lw` bytes wide, is copied into every device lane until the bank width is filled.
- R8: In identifier mode only the low 8 bits of the index are decoded. 0 gives `ID_MFR` and 1 gives `ID_DEV`, each cut to the device width with its low byte in lane byte 0. Any other value gives zero.
- R9: A read wider than the bank is built by concatenating bank-wide pieces. Piece k covers byte lanes k·2^bank_lw upward and is looked up at address + k·2^bank_lw.
- R10: Output bytes at or above 2^`acc_lw` are zero.
- R11: The width settings are captured only in cycles with `req` = 0. A request reads with the values held from the last idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request, one cycle per read |
| qmode | input | 1 | 1 = query table, 0 = identifier codes |
| addr | input | AW | Byte address of the read |
| acc_lw | input | LW | log2 of access width in bytes |
| cfg_bank_lw | input | LW | log2 of bank width in bytes |
| cfg_dev_lw | input | LW | log2 of device width in use |
| cfg_max_lw | input | LW | log2 of largest device width |
| rdata | output | 8*NB | Assembled read word |
| rvalid | output | 1 | Read word valid, one cycle after req |

## Verification
The bench builds the block with a four-byte data path, a 16-bit address and a non-zero `QTAB_LAST`. The non-zero last entry lets the table-end boundary at index 81/82 be seen at the port. `ID_DEV` is set to 0x8A18, so its upper byte shows whether a two-byte device returns its full code and a byte-wide device cuts it. The four-byte path covers bank widths of one, two and four bytes. It also covers a 16-bit device used in byte mode on a 2- and 4-byte bank, and a read that spans two to four bank pieces.

// File: rtl/flash_query_resp.sv
module flash_query_resp #(
  parameter int AW = 16,
  parameter int NB = 4,
  parameter int QTAB_DEPTH = 82,
  parameter logic [7:0] QTAB_LAST = 8'h00,
  parameter logic [15:0] ID_MFR = 16'h0089,
  parameter logic [15:0] ID_DEV = 16'h8A18,
  parameter int LW = ($clog2(NB) < 1) ? 1 : $clog2($clog2(NB) + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            qmode,
  input  logic [AW-1:0]   addr,
  input  logic [LW-1:0]   acc_lw,
  input  logic [LW-1:0]   cfg_bank_lw,
  input  logic [LW-1:0]   cfg_dev_lw,
  input  logic [LW-1:0]   cfg_max_lw,
  output logic [8*NB-1:0] rdata,
  output logic            rvalid
);
  localparam int IDW = (8*NB > 16) ? 8*NB : 16;
  localparam logic [AW-1:0] QDEPTH = AW'(QTAB_DEPTH);

  logic [LW-1:0] bank_r, dev_r, max_r;
  logic [8*NB-1:0] lanes;
  int lb, ld, lm, sh, al;

  assign lb = int'(bank_r);
  assign ld = int'(dev_r);
  assign lm = int'(max_r);
  assign sh = lb + lm - ld;
  assign al = int'(acc_lw);

  function automatic logic [7:0] qtab(input logic [AW-1:0] i);
    logic [7:0] v;
    v = 8'h00;
    if (i == AW'(16)) v = 8'h51;
    if (i == AW'(17)) v = 8'h52;
    if (i == AW'(18)) v = 8'h59;
    if (i == AW'(19)) v = 8'h01;
    if (i == AW'(QTAB_DEPTH - 1)) v = QTAB_LAST;
    return v;
  endfunction

  always_comb begin
    int k, b, m;
    logic [AW-1:0] ca, ix;
    logic [7:0] v;
    logic [IDW-1:0] idw;
    lanes = '0;
    for (int j = 0; j < NB; j++) begin
      k   = j >> lb;
      b   = j & ((1 << lb) - 1);
      m   = b & ((1 << ld) - 1);
      ca  = addr + AW'(k << lb);
      ix  = ca >> sh;
      idw = '0;
      if (qmode) begin
        v = (ix < QDEPTH) ? qtab(ix) : 8'h00;
        if (m != 0 && ld == lm) v = 8'h00;
      end else begin
        if (ix[7:0] == 8'd0) idw = IDW'(ID_MFR);
        else if (ix[7:0] == 8'd1) idw = IDW'(ID_DEV);
        v = idw[8*m +: 8];
      end
      if (j >= (1 << al)) v = 8'h00;
      lanes[8*j +: 8] = v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_r <= '0;
      dev_r  <= '0;
      max_r  <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= req;
      if (req) begin
        rdata <= lanes;
      end else begin
        bank_r <= cfg_bank_lw;
        dev_r  <= cfg_dev_lw;
        max_r  <= cfg_max_lw;
      end
    end
  end
endmodule

// File: rtl/flash_query_resp_chk.sv
module flash_query_resp_chk #(
  parameter int AW = 16,
  parameter int NB = 4,
  parameter int QTAB_DEPTH = 82,
  parameter int LW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req,
  input logic            qmode,
  input logic [AW-1:0]   addr,
  input logic [LW-1:0]   acc_lw,
  input logic [8*NB-1:0] rdata,
  input logic            rvalid
);
  localparam int MAXSH = 2 * $clog2(NB);
  localparam longint FAR_LO = longint'(QTAB_DEPTH) << MAXSH;
  localparam longint FAR_HI = (longint'(1) << AW) - longint'(NB * NB);

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> rvalid); // R2
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !rvalid); // R2
  AST_DATA_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(rdata)); // R2
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req && acc_lw == '0) |=> (rdata[8*NB-1:8] == '0)); // R10
  AST_FAR_QUERY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req && qmode && longint'(addr) >= FAR_LO && longint'(addr) < FAR_HI)
      |=> (rdata == '0)); // R4
endmodule

bind flash_query_resp flash_query_resp_chk #(
  .AW(AW), .NB(NB), .QTAB_DEPTH(QTAB_DEPTH), .LW(LW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .qmode(qmode), .addr(addr),
  .acc_lw(acc_lw), .rdata(rdata), .rvalid(rvalid)
);

// File: tb/flash_query_resp_test.sv
module flash_query_resp_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        qmode = 1'b0;
  logic [15:0] addr = '0;
  logic [1:0]  acc_lw = '0, bank_lw = '0, dev_lw = '0, max_lw = '0;
  logic [31:0] rdata;
  logic        rvalid;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  flash_query_resp #(
    .AW(16), .NB(4), .QTAB_DEPTH(82), .QTAB_LAST(8'hA5),
    .ID_MFR(16'h0089), .ID_DEV(16'h8A18)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .qmode(qmode), .addr(addr),
    .acc_lw(acc_lw), .cfg_bank_lw(bank_lw), .cfg_dev_lw(dev_lw),
    .cfg_max_lw(max_lw), .rdata(rdata), .rvalid(rvalid)
  );

  // {tag[60:57], qmode[56], bank[55:54], dev[53:52], max[51:50], acc[49:48], addr[47:32], expected[31:0]}
  localparam logic [60:0] VEC [15] = '{
    {4'd5,  1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 16'h0010, 32'h00000051}, // R5 'Q'
    {4'd9,  1'b1, 2'd0, 2'd0, 2'd0, 2'd2, 16'h0010, 32'h01595251}, // R9 four pieces
    {4'd6,  1'b1, 2'd1, 2'd1, 2'd1, 2'd1, 16'h0020, 32'h00000051}, // R6 x16 zero upper
    {4'd7,  1'b1, 2'd1, 2'd0, 2'd0, 2'd1, 16'h0022, 32'h00005252}, // R7 two x8
    {4'd7,  1'b1, 2'd2, 2'd1, 2'd1, 2'd2, 16'h0048, 32'h00590059}, // R7 two x16
    {4'd3,  1'b1, 2'd2, 2'd0, 2'd1, 2'd2, 16'h0098, 32'h01010101}, // R3 x16 in x8, bank 4
    {4'd3,  1'b1, 2'd1, 2'd0, 2'd1, 2'd1, 16'h0040, 32'h00005151}, // R3 x16 in x8, bank 2
    {4'd4,  1'b1, 2'd0, 2'd0, 2'd0, 2'd1, 16'h0051, 32'h000000A5}, // R4 index 81/82
    {4'd9,  1'b0, 2'd0, 2'd0, 2'd0, 2'd1, 16'h0000, 32'h00001889}, // R9 ident pieces
    {4'd8,  1'b0, 2'd1, 2'd1, 2'd1, 2'd1, 16'h0002, 32'h00008A18}, // R8 device code x16
    {4'd8,  1'b0, 2'd1, 2'd1, 2'd1, 2'd1, 16'h0200, 32'h00000089}, // R8 high bits ignored
    {4'd7,  1'b0, 2'd2, 2'd1, 2'd1, 2'd2, 16'h0004, 32'h8A188A18}, // R7 ident replicated
    {4'd8,  1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 16'h0002, 32'h00000000}, // R8 other index
    {4'd10, 1'b1, 2'd2, 2'd0, 2'd0, 2'd1, 16'h0040, 32'h00005151}, // R10 narrow access
    {4'd8,  1'b0, 2'd2, 2'd0, 2'd1, 2'd2, 16'h0008, 32'h18181818}  // R8 byte-mode ident
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] b, input logic [1:0] d, input logic [1:0] m);
    @(negedge clk);
    bank_lw = b; dev_lw = d; max_lw = m; req = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_read(input logic q, input logic [1:0] a, input logic [15:0] ad);
    @(negedge clk);
    qmode = q; acc_lw = a; addr = ad; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rvalid in reset", {31'b0, rvalid}, 32'h0);
    check("R1 rdata in reset", rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata after reset", rdata, 32'h0);

    for (int i = 0; i < 15; i++) begin
      set_cfg(VEC[i][55:54], VEC[i][53:52], VEC[i][51:50]);
      do_read(VEC[i][56], VEC[i][49:48], VEC[i][47:32]);
      check($sformatf("R%0d vector %0d", VEC[i][60:57], i), rdata, VEC[i][31:0]);
    end

    // R2: valid pulse and hold
    set_cfg(2'd0, 2'd0, 2'd0);
    do_read(1'b1, 2'd0, 16'h0011);
    check("R2 rvalid pulse", {31'b0, rvalid}, 32'h1);
    check("R2 read data", rdata, 32'h00000052);
    addr = 16'h0012;
    repeat (3) @(negedge clk);
    check("R2 rvalid idle", {31'b0, rvalid}, 32'h0);
    check("R2 rdata held", rdata, 32'h00000052);

    // R11: settings changing with a request are not used for it
    set_cfg(2'd0, 2'd0, 2'd0);
    @(negedge clk);
    bank_lw = 2'd2; qmode = 1'b1; acc_lw = 2'd0; addr = 16'h0010; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check("R11 old settings used", rdata, 32'h00000051);
    do_read(1'b1, 2'd0, 16'h0010);
    check("R11 new settings after idle", rdata, 32'h00000000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule